// File: doc/BRIEF.md
# Framed Serial Command Decoder with One-Time Trim Store

The block sits behind a single-wire pulse-width bit recovery stage. Every recovered bit arrives as a one-cycle strobe with its value, and is shifted into a 38-bit window. When the window holds a well-formed command, the block acts on it once. A well-formed command has a fixed opening mark, a two-bit opcode, a two-bit target selector, a fixed two-bit divider, an eight-bit operand and a fixed closing mark.

There are four opcodes. The first picks the sensing-current level. The second writes a volatile trim register. The third raises a one-hot burn strobe towards a register-modelled one-time fuse array of 20 bits. The fourth captures a trim value for readback.

The block drives the three trim codes that are in use: a 3-bit coarse gain, a 7-bit fine gain and an 8-bit output offset. They come from the volatile registers until the lock fuse is burned. From then on they come only from the fuse array.

Top module: `cmd_frame_decoder`

## Requirements
- R1: Bits enter the window oldest-first. Command bit 0 is the first bit received. A command is acted on only when four things hold: bits 0..11 are 1000_0000_0001, bits 16..17 are 10, bits 26..37 are 0111_1111_1110 (all written first-received to last-received), and the last of the 38 bits has just arrived. If any of these marks is wrong, nothing changes.
- R2: Opcode (bits 12..13) 01 writes a volatile register. The target is chosen by bits 14..15: 00 is coarse gain, 01 is fine gain, 10 is offset. The write takes the low 3, 7 or 8 bits of the operand (bits 18..25, most significant first). Target 11 is ignored.
- R3: Opcode 00 sets `lowSense` to operand bit 0, where 1 means low current. This works whether or not the block is locked.
- R4: After reset, every trim output is 0, `lowSense` is 0, `burnStrobe` is 0, `progError` is 0 and `masterLocked` is 0.
- R5: Opcode 10 with an operand that has exactly one bit b set raises `burnStrobe` bit (base + b). The bases are 0 for coarse, 3 for fine, 10 for offset and 18 for other. The strobe rises one clock after the last bit, stays up while the window is unchanged, and drops on the clock that shifts in the next bit.
- R6: In opcode 10, an operand that does not have exactly one bit set is refused, as is a set bit that lies beyond the target's width (coarse 3, fine 7, offset 8, other 2). A refused command raises `progError` and no strobe. `progError` is held until the next accepted command.
- R7: No strobe is raised for a fuse that is already burned, and no error is flagged for it.
- R8: Burning fuse 18 (target other, operand bit 0) sets `masterLocked` for good. After that, opcode 01 and opcode 10 commands have no effect.
- R9: Opcode 11 pulses `readStart` for one cycle, one clock after the last bit. In the same cycle `readValue` shows the active value of the target, zero-extended. For target other, the value is fuse 19 and fuse 18 in bits 1..0.
- R10: While unlocked, the trim outputs come from the volatile registers and burned fuses do not affect them. Once locked, coarse comes from fuses 2..0, fine from fuses 9..3 and offset from fuses 17..10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | One-cycle strobe for a recovered bit |
| bitData | input | 1 | Value of the recovered bit |
| coarseGain | output | 3 | Active coarse gain code |
| fineGain | output | 7 | Active fine gain code |
| offsetCode | output | 8 | Active output offset code |
| lowSense | output | 1 | Low sensing-current select |
| burnStrobe | output | 20 | One-hot burn request to the fuse array |
| masterLocked | output | 1 | Lock fuse is burned |
| progError | output | 1 | Last burn command was refused |
| readStart | output | 1 | Readback start pulse |
| readValue | output | 8 | Value captured for readback |

## Verification
The hardest state to reach from the ports is the locked one. Getting there takes a full command that burns exactly one fuse, and the fuse must be the lock, so no random stream will arrive there by chance. The bench first runs seeded random streams of sense, simulate and read commands, with some marks corrupted, against a bench model. It then runs a directed burn sequence: single-bit burns, repeated burns, refused operands, and finally the lock. After the lock it checks that trim writes and further burns leave the fuse-sourced outputs alone, while sense and readback still work.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int FRAME_BITS  = 38;
  localparam int MARK_BITS   = 12;
  localparam int VAL_BITS    = 8;
  localparam int COARSE_BITS = 3;
  localparam int FINE_BITS   = 7;
  localparam int OFFS_BITS   = 8;
  localparam int OTHER_BITS  = 2;
  localparam int FUSE_COUNT  = COARSE_BITS + FINE_BITS + OFFS_BITS + OTHER_BITS;
  localparam int FUSE_IDX_W  = $clog2(FUSE_COUNT);
  localparam int VAL_IDX_W   = $clog2(VAL_BITS);
  localparam int COARSE_BASE = 0;
  localparam int FINE_BASE   = COARSE_BASE + COARSE_BITS;
  localparam int OFFS_BASE   = FINE_BASE + FINE_BITS;
  localparam int OTHER_BASE  = OFFS_BASE + OFFS_BITS;
  localparam int LOCK_IDX    = OTHER_BASE;
  // field positions inside the window (first received bit sits at the top)
  localparam int FN_HI  = FRAME_BITS - MARK_BITS - 1;
  localparam int SEL_HI = FN_HI - 2;
  localparam int SEP_HI = SEL_HI - 2;
  localparam int VAL_HI = SEP_HI - 2;
  localparam logic [MARK_BITS-1:0] OPEN_MARK  = 12'b1000_0000_0001;
  localparam logic [MARK_BITS-1:0] CLOSE_MARK = 12'b0111_1111_1110;
  localparam logic [1:0]           SEP_MARK   = 2'b10;

  typedef enum logic [1:0] {FN_SENSE = 2'b00, FN_SIM = 2'b01, FN_BURN = 2'b10, FN_READ = 2'b11} fn_e;
  typedef enum logic [1:0] {SEL_COARSE = 2'b00, SEL_FINE = 2'b01, SEL_OFFS = 2'b10, SEL_OTHER = 2'b11} sel_e;

  typedef struct packed {
    logic simWr;
    logic senseWr;
    logic readCap;
  } ctlStrobe_t;
endpackage

// File: rtl/cfd_datapath.sv
module cfd_datapath
  import cfd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bitValid,
  input  logic                   bitData,
  input  ctlStrobe_t             ctl,
  input  logic [FUSE_COUNT-1:0]  burnVec,
  output logic                   frameOk,
  output fn_e                    fFunc,
  output sel_e                   fSel,
  output logic [VAL_BITS-1:0]    fValue,
  output logic [FUSE_COUNT-1:0]  fuseBits,
  output logic                   locked,
  output logic [COARSE_BITS-1:0] coarseOut,
  output logic [FINE_BITS-1:0]   fineOut,
  output logic [OFFS_BITS-1:0]   offsOut,
  output logic                   lowSense,
  output logic [VAL_BITS-1:0]    readValue
);
  logic [FRAME_BITS-1:0]  window;
  logic [COARSE_BITS-1:0] simCoarse;
  logic [FINE_BITS-1:0]   simFine;
  logic [OFFS_BITS-1:0]   simOffs;
  logic [MARK_BITS-1:0]   openField;
  logic [MARK_BITS-1:0]   closeField;
  logic [1:0]             sepField;

  always_ff @(posedge clk) begin
    if (!rstN) window <= '0;
    else if (bitValid) window <= {window[FRAME_BITS-2:0], bitData};
  end

  assign openField  = window[FRAME_BITS-1 -: MARK_BITS];
  assign closeField = window[MARK_BITS-1:0];
  assign sepField   = window[SEP_HI -: 2];
  assign fFunc      = fn_e'(window[FN_HI -: 2]);
  assign fSel       = sel_e'(window[SEL_HI -: 2]);
  assign fValue     = window[VAL_HI -: VAL_BITS];
  assign frameOk    = (openField == OPEN_MARK) && (sepField == SEP_MARK) && (closeField == CLOSE_MARK);

  // volatile trim registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      simCoarse <= '0;
      simFine   <= '0;
      simOffs   <= '0;
    end else if (ctl.simWr) begin
      case (fSel)
        SEL_COARSE: simCoarse <= fValue[COARSE_BITS-1:0];
        SEL_FINE:   simFine   <= fValue[FINE_BITS-1:0];
        SEL_OFFS:   simOffs   <= fValue[OFFS_BITS-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lowSense <= 1'b0;
    else if (ctl.senseWr) lowSense <= fValue[0];
  end

  // one-time store: a bit only ever goes from 0 to 1
  genvar gi;
  generate
    for (gi = 0; gi < FUSE_COUNT; gi++) begin : g_fuse
      always_ff @(posedge clk) begin
        if (!rstN) fuseBits[gi] <= 1'b0;
        else if (burnVec[gi]) fuseBits[gi] <= 1'b1;
      end
    end
  endgenerate

  assign locked = fuseBits[LOCK_IDX];

  always_comb begin
    if (locked) begin
      coarseOut = fuseBits[COARSE_BASE +: COARSE_BITS];
      fineOut   = fuseBits[FINE_BASE +: FINE_BITS];
      offsOut   = fuseBits[OFFS_BASE +: OFFS_BITS];
    end else begin
      coarseOut = simCoarse;
      fineOut   = simFine;
      offsOut   = simOffs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) readValue <= '0;
    else if (ctl.readCap) begin
      case (fSel)
        SEL_COARSE: readValue <= {{(VAL_BITS-COARSE_BITS){1'b0}}, coarseOut};
        SEL_FINE:   readValue <= {{(VAL_BITS-FINE_BITS){1'b0}}, fineOut};
        SEL_OFFS:   readValue <= offsOut;
        default:    readValue <= {{(VAL_BITS-OTHER_BITS){1'b0}}, fuseBits[OTHER_BASE +: OTHER_BITS]};
      endcase
    end
  end
endmodule

// File: rtl/cfd_control.sv
module cfd_control
  import cfd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitValid,
  input  logic                  frameOk,
  input  fn_e                   fFunc,
  input  sel_e                  fSel,
  input  logic [VAL_BITS-1:0]   fValue,
  input  logic [FUSE_COUNT-1:0] fuseBits,
  input  logic                  locked,
  output ctlStrobe_t            ctl,
  output logic [FUSE_COUNT-1:0] burnVec,
  output logic                  progError,
  output logic                  readStart
);
  logic                  justShifted;
  logic                  accept;
  int                    onesCnt;
  logic [VAL_IDX_W-1:0]  bitPos;
  int                    grpBase;
  int                    grpWidth;
  logic                  valOk;
  logic [FUSE_IDX_W-1:0] tgtIdx;
  logic                  isBurn;
  logic                  burnReq;

  // act only in the cycle right after the closing bit arrived
  always_ff @(posedge clk) begin
    if (!rstN) justShifted <= 1'b0;
    else justShifted <= bitValid;
  end

  assign accept = justShifted && frameOk;

  always_comb begin
    onesCnt = 0;
    bitPos  = '0;
    for (int i = 0; i < VAL_BITS; i++) begin
      if (fValue[i]) begin
        onesCnt = onesCnt + 1;
        bitPos  = VAL_IDX_W'(i);
      end
    end
  end

  always_comb begin
    case (fSel)
      SEL_COARSE: begin grpBase = COARSE_BASE; grpWidth = COARSE_BITS; end
      SEL_FINE:   begin grpBase = FINE_BASE;   grpWidth = FINE_BITS;   end
      SEL_OFFS:   begin grpBase = OFFS_BASE;   grpWidth = OFFS_BITS;   end
      default:    begin grpBase = OTHER_BASE;  grpWidth = OTHER_BITS;  end
    endcase
  end

  assign valOk   = (onesCnt == 1) && (int'(bitPos) < grpWidth);
  assign tgtIdx  = FUSE_IDX_W'(grpBase + int'(bitPos));
  assign isBurn  = accept && (fFunc == FN_BURN) && !locked;
  assign burnReq = isBurn && valOk && !fuseBits[tgtIdx];

  assign ctl.simWr   = accept && (fFunc == FN_SIM) && (fSel != SEL_OTHER) && !locked;
  assign ctl.senseWr = accept && (fFunc == FN_SENSE);
  assign ctl.readCap = accept && (fFunc == FN_READ);

  // strobe held while the window is unchanged, dropped as the next bit shifts
  always_ff @(posedge clk) begin
    if (!rstN) burnVec <= '0;
    else if (bitValid) burnVec <= '0;
    else if (burnReq) burnVec <= FUSE_COUNT'(1) << tgtIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) progError <= 1'b0;
    else if (accept) progError <= isBurn && !valOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) readStart <= 1'b0;
    else readStart <= ctl.readCap;
  end
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
  import cfd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bitValid,
  input  logic                   bitData,
  output logic [COARSE_BITS-1:0] coarseGain,
  output logic [FINE_BITS-1:0]   fineGain,
  output logic [OFFS_BITS-1:0]   offsetCode,
  output logic                   lowSense,
  output logic [FUSE_COUNT-1:0]  burnStrobe,
  output logic                   masterLocked,
  output logic                   progError,
  output logic                   readStart,
  output logic [VAL_BITS-1:0]    readValue
);
  ctlStrobe_t            ctl;
  logic                  frameOk;
  fn_e                   fFunc;
  sel_e                  fSel;
  logic [VAL_BITS-1:0]   fValue;
  logic [FUSE_COUNT-1:0] fuseBits;

  cfd_datapath dp_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .ctl(ctl), .burnVec(burnStrobe), .frameOk(frameOk), .fFunc(fFunc),
    .fSel(fSel), .fValue(fValue), .fuseBits(fuseBits), .locked(masterLocked),
    .coarseOut(coarseGain), .fineOut(fineGain), .offsOut(offsetCode),
    .lowSense(lowSense), .readValue(readValue)
  );

  cfd_control ct_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .frameOk(frameOk),
    .fFunc(fFunc), .fSel(fSel), .fValue(fValue), .fuseBits(fuseBits),
    .locked(masterLocked), .ctl(ctl), .burnVec(burnStrobe),
    .progError(progError), .readStart(readStart)
  );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker
  import cfd_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   bitValid,
  input logic [COARSE_BITS-1:0] coarseGain,
  input logic [FINE_BITS-1:0]   fineGain,
  input logic [OFFS_BITS-1:0]   offsetCode,
  input logic [FUSE_COUNT-1:0]  burnStrobe,
  input logic                   masterLocked,
  input logic                   progError,
  input logic                   readStart
);
  AST_BURN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(burnStrobe)); // R5
  AST_BURN_DROP: assert property (@(posedge clk) disable iff (!rstN) bitValid |=> burnStrobe == '0); // R5
  AST_ERR_NO_BURN: assert property (@(posedge clk) disable iff (!rstN) $rose(progError) |-> burnStrobe == '0); // R6
  AST_NO_BURN_LOCKED: assert property (@(posedge clk) disable iff (!rstN) $rose(|burnStrobe) |-> !$past(masterLocked)); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN) $past(masterLocked) |-> masterLocked); // R8
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (masterLocked && $past(masterLocked)) |-> $stable({coarseGain, fineGain, offsetCode})); // R8
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rstN) readStart |=> !readStart); // R9
endmodule

bind cmd_frame_decoder cfd_checker chk_i (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .coarseGain(coarseGain),
  .fineGain(fineGain), .offsetCode(offsetCode), .burnStrobe(burnStrobe),
  .masterLocked(masterLocked), .progError(progError), .readStart(readStart)
);

// File: tb/cmd_frame_decoder_tb.sv
`timescale 1ns/1ps
module cmd_frame_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic bitData = 1'b0;
  logic [2:0]  coarseGain;
  logic [6:0]  fineGain;
  logic [7:0]  offsetCode;
  logic        lowSense;
  logic [19:0] burnStrobe;
  logic        masterLocked;
  logic        progError;
  logic        readStart;
  logic [7:0]  readValue;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  // bench model
  logic [2:0]  mCoarse = '0;
  logic [6:0]  mFine = '0;
  logic [7:0]  mOffs = '0;
  logic        mLow = 1'b0;
  logic [19:0] mFuse = '0;

  always #2.5 clk = ~clk;

  cmd_frame_decoder dut_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .coarseGain(coarseGain), .fineGain(fineGain), .offsetCode(offsetCode),
    .lowSense(lowSense), .burnStrobe(burnStrobe), .masterLocked(masterLocked),
    .progError(progError), .readStart(readStart), .readValue(readValue)
  );

  function automatic logic [37:0] mkFrame(input logic [1:0] fn, input logic [1:0] sel, input logic [7:0] val);
    return {12'b1000_0000_0001, fn, sel, 2'b10, val, 12'b0111_1111_1110};
  endfunction

  function automatic logic [18:0] expTrim();
    if (mFuse[18]) return {mFuse[2:0], mFuse[9:3], mFuse[17:10], 1'b1};
    return {mCoarse, mFine, mOffs, 1'b0};
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] sel);
    logic [18:0] t;
    t = expTrim();
    case (sel)
      2'd0: return {5'd0, t[18:16]};
      2'd1: return {1'b0, t[15:9]};
      2'd2: return t[8:1];
      default: return {6'd0, mFuse[19:18]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkOutputs(input string req);
    chk(req, {13'd0, coarseGain, fineGain, offsetCode, masterLocked}, {13'd0, expTrim()});
    chk(req, {31'd0, lowSense}, {31'd0, mLow});
  endtask

  task automatic sendFrame(input logic [37:0] f);
    for (int i = 37; i >= 0; i--) begin
      @(negedge clk);
      bitValid = 1'b1;
      bitData = f[i];
      @(negedge clk);
      bitValid = 1'b0;
    end
  endtask

  // burn command, sampled one clock after the last bit and again later
  task automatic burnCmd(input logic [1:0] sel, input logic [7:0] val, input logic [19:0] expVec,
                         input logic expErr, input string req);
    sendFrame(mkFrame(2'b10, sel, val));
    @(negedge clk);
    chk(req, {12'd0, burnStrobe}, {12'd0, expVec});
    chk(req, {31'd0, progError}, {31'd0, expErr});
    repeat (3) @(negedge clk);
    chk(req, {12'd0, burnStrobe}, {12'd0, expVec});
    mFuse = mFuse | expVec;
    chkOutputs("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [37:0] f;
    logic [1:0] fn, sel;
    logic [7:0] val;
    bit bad;
    int r, k;
    void'($urandom(32'd1789));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    chkOutputs("R4");
    chk("R4", {12'd0, burnStrobe}, 32'd0);
    chk("R4", {31'd0, progError}, 32'd0);

    // random sense / simulate / read traffic with corrupted marks (R1 R2 R3 R9)
    for (int n = 0; n < 70; n++) begin
      r = int'($urandom % 3);
      fn = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      sel = 2'($urandom % 4);
      val = 8'($urandom % 256);
      bad = (($urandom % 5) == 0);
      f = mkFrame(fn, sel, val);
      if (bad) begin
        r = int'($urandom % 26);
        k = (r < 12) ? r : (r < 14) ? 16 + (r - 12) : 26 + (r - 14);
        f[37-k] = ~f[37-k];
      end
      sendFrame(f);
      @(negedge clk);
      if (bad) begin
        chk("R1", {31'd0, readStart}, 32'd0);
      end else if (fn == 2'b11) begin
        chk("R9", {31'd0, readStart}, 32'd1);
        chk("R9", {24'd0, readValue}, {24'd0, expRead(sel)});
      end else if (fn == 2'b00) begin
        mLow = val[0];
      end else begin
        case (sel)
          2'd0: mCoarse = val[2:0];
          2'd1: mFine = val[6:0];
          2'd2: mOffs = val;
          default: ;
        endcase
      end
      @(negedge clk);
      chkOutputs(bad ? "R1" : (fn == 2'b01) ? "R2" : "R3");
      chk("R9", {31'd0, readStart}, 32'd0);
    end

    // directed: simulate target 11 ignored (R2)
    sendFrame(mkFrame(2'b01, 2'b11, 8'hFF));
    repeat (2) @(negedge clk);
    chkOutputs("R2");

    // burns while unlocked (R5 R10)
    burnCmd(2'b00, 8'h04, 20'h00004, 1'b0, "R5");
    burnCmd(2'b00, 8'h04, 20'h00000, 1'b0, "R7");
    burnCmd(2'b01, 8'h03, 20'h00000, 1'b1, "R6");
    burnCmd(2'b01, 8'h80, 20'h00000, 1'b1, "R6");
    burnCmd(2'b11, 8'h04, 20'h00000, 1'b1, "R6");
    burnCmd(2'b11, 8'h00, 20'h00000, 1'b1, "R6");
    burnCmd(2'b01, 8'h01, 20'h00008, 1'b0, "R5");
    burnCmd(2'b10, 8'h80, 20'h20000, 1'b0, "R5");
    burnCmd(2'b11, 8'h02, 20'h80000, 1'b0, "R5");

    // readback of other group before lock (R9)
    sendFrame(mkFrame(2'b11, 2'b11, 8'h00));
    @(negedge clk);
    chk("R9", {31'd0, readStart}, 32'd1);
    chk("R9", {24'd0, readValue}, 32'h2);

    // lock (R8)
    burnCmd(2'b11, 8'h01, 20'h40000, 1'b0, "R8");
    chk("R8", {31'd0, masterLocked}, 32'd1);
    chkOutputs("R8");

    sendFrame(mkFrame(2'b01, 2'b10, 8'h55));
    repeat (2) @(negedge clk);
    chkOutputs("R8");
    burnCmd(2'b10, 8'h01, 20'h00000, 1'b0, "R8");
    burnCmd(2'b00, 8'h03, 20'h00000, 1'b0, "R8");

    sendFrame(mkFrame(2'b00, 2'b00, 8'h01));
    mLow = 1'b1;
    repeat (2) @(negedge clk);
    chkOutputs("R3");

    sendFrame(mkFrame(2'b11, 2'b10, 8'h00));
    @(negedge clk);
    chk("R9", {31'd0, readStart}, 32'd1);
    chk("R9", {24'd0, readValue}, 32'h80);
    sendFrame(mkFrame(2'b11, 2'b11, 8'h00));
    @(negedge clk);
    chk("R9", {24'd0, readValue}, 32'h3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule